// File: doc/BRIEF.md
# Hardware Cursor Window Clipper and Pattern Loader

This block places a small hardware cursor on the active display. It takes a signed cursor position, the cursor bitmap size and the size of the active display. It works out the part of the cursor that is actually on screen: the screen coordinate of its top-left corner, its visible width and height, and the pixel index in the bitmap where the visible part begins. Clipping is done on all four edges. In interlaced scan the vertical screen coordinate and the visible height are halved, and the bitmap row stride is doubled.

The computed position and size are not applied at once. They are held and take effect on the next frame-done pulse, so the cursor never changes in the middle of a frame. A second path writes the cursor pattern into a banked pattern SRAM. Each incoming ARGB pixel has its red and blue bytes exchanged, and the block generates the bank-hopping address sequence for it. After the SRAM powers up, the block fills the transparency table before any pattern is accepted.

A geometry change that alters the visible size turns the cursor off. The cursor stays off until the new pattern has been streamed in and the next frame-done has committed the new size.

Top module: `hwcur_unit`

## Requirements
- R1: A request whose width or height exceeds 64, or whose width and height both exceed 32, raises `req_reject` in the next cycle and changes no output. A 64x32 request is accepted.
- R2: A negative x gives a screen x of 0, a bitmap column skip of −x, and a visible width of width − (−x), floored at 0. The vertical axis uses the same rule.
- R3: When x + width exceeds the active width, the visible width is max(active width − x, 0) and the screen x stays at x. The vertical axis uses the same rule.
- R4: With `interlace` high, the bitmap stride is 2·width, and the screen y and the visible height are the clipped values halved (rounded down).
- R5: An accepted request whose visible width or visible height is 0 drives `cursor_en` low in the next cycle.
- R6: `cur_pos` is screen_y<<16 | screen_x and `cur_size` is visible_h<<16 | visible_w. Both load, and `cursor_en` rises, only in the cycle after a `frame_done` pulse, when a request is pending and no pattern load is in progress.
- R7: Each pattern pixel is written as {p[31:24], p[7:0], p[15:8], p[23:16]}.
- R8: Pattern writes start at 0x0C00 and step by 1. When the low 8 bits wrap to 0, 0xF00 is added. When (address & 0x30FF) is 0, the address becomes 0x0D00.
- R9: A `sram_pwr_up` pulse clears `cursor_en` in the next cycle and writes 0x55555555 to addresses 0x0E00 to 0x0EFF in order. `pix_ready` stays low until those writes finish, and the next visible request reloads the pattern.
- R10: An accepted visible request whose visible size differs from the loaded pattern drops `cursor_en` in the next cycle and raises `pix_ready`. Exactly visible_w·visible_h pixels are then taken, and `cursor_en` returns only after those pixels and a commit.
- R11: A visible request that keeps the loaded size and has `req_reload` low starts no load and keeps `cursor_en` high. The new position is applied at the next `frame_done`.
- R12: `bmp_off` is row_skip·stride + column_skip. It is updated in the cycle after each accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Geometry request strobe |
| req_reload | input | 1 | Request also carries a new pattern |
| req_x | input | 13 | Signed cursor x |
| req_y | input | 13 | Signed cursor y |
| req_w | input | 7 | Cursor bitmap width |
| req_h | input | 7 | Cursor bitmap height |
| act_w | input | 12 | Active display width |
| act_h | input | 12 | Active display height |
| interlace | input | 1 | Interlaced scan |
| frame_done | input | 1 | End-of-frame pulse, commit point |
| sram_pwr_up | input | 1 | Pattern SRAM has just powered up |
| pix_valid | input | 1 | Pattern pixel offered |
| pix_data | input | 32 | ARGB pattern pixel |
| pix_ready | output | 1 | Pattern pixel taken this cycle when valid |
| req_reject | output | 1 | Previous request was oversize |
| cur_pos | output | 32 | Committed packed screen position |
| cur_size | output | 32 | Committed packed visible size |
| bmp_off | output | 14 | Bitmap pixel index of first visible pixel |
| cursor_en | output | 1 | Cursor display enable |
| sram_we | output | 1 | Pattern SRAM write strobe |
| sram_addr | output | 16 | Pattern SRAM address |
| sram_wdata | output | 32 | Pattern SRAM write data |

## Verification
The hardest case to reach is a geometry request that arrives while the transparency fill is still running after a power-up. In that case the pattern load is armed, but it must not take any pixel until the 256 fill writes have drained, and the fill must come before any pattern write on the shared port. The stimulus pulses `sram_pwr_up` while the cursor is enabled, sends a request one cycle later, and offers pixels straight away. The scoreboard queue holds the 256 fill writes ahead of the pattern writes, so any interleaving or lost write shows up as a mismatch. A full 64x32 load covers every low-byte wrap and the jump to the second bank.

// File: rtl/hwcur_pkg.sv
package hwcur_pkg;

  localparam int unsigned SRAM_AW   = 16;
  localparam int unsigned PIX_W     = 32;
  localparam logic [SRAM_AW-1:0] BANK_HOP  = 16'h0F00;
  localparam logic [SRAM_AW-1:0] WRAP_MASK = 16'h30FF;

  // exchange the red and blue bytes, keep alpha and green
  function automatic logic [PIX_W-1:0] argb_swap(input logic [PIX_W-1:0] p);
    return {p[31:24], p[7:0], p[15:8], p[23:16]};
  endfunction

  // pattern address step with bank hopping
  function automatic logic [SRAM_AW-1:0] addr_step(input logic [SRAM_AW-1:0] a,
                                                   input logic [SRAM_AW-1:0] second_base);
    logic [SRAM_AW-1:0] n;
    n = a + 1'b1;
    if (n[7:0] == 8'h00) n = n + BANK_HOP;
    if ((n & WRAP_MASK) == '0) n = second_base;
    return n;
  endfunction

endpackage

// File: rtl/hwcur_axis.sv
module hwcur_axis #(
  parameter int unsigned POS_W = 13,
  parameter int unsigned LEN_W = 7,
  parameter int unsigned LIM_W = 12
) (
  input  logic signed [POS_W-1:0] pos,
  input  logic [LEN_W-1:0]        len,
  input  logic [LIM_W-1:0]        lim,
  output logic [LIM_W-1:0]        scr,
  output logic [LEN_W-1:0]        vis,
  output logic [LEN_W-1:0]        skip
);

  logic [POS_W-1:0] mag;
  logic [POS_W-1:0] pos_u;
  logic [POS_W-1:0] lim_x;
  logic [POS_W-1:0] room;
  logic [POS_W:0]   far_end;

  always_comb begin
    mag     = -pos;
    pos_u   = pos;
    lim_x   = POS_W'(lim);
    room    = lim_x - pos_u;
    far_end = {1'b0, pos_u} + (POS_W+1)'(len);
    skip    = '0;
    scr     = pos_u[LIM_W-1:0];
    vis     = len;
    if (pos[POS_W-1]) begin
      scr  = '0;
      skip = (mag > POS_W'(len)) ? len : mag[LEN_W-1:0];
      vis  = len - skip;
    end else if (far_end > (POS_W+1)'(lim)) begin
      vis = (lim_x > pos_u) ? room[LEN_W-1:0] : '0;
    end
  end

endmodule

// File: rtl/hwcur_loader.sv
module hwcur_loader
  import hwcur_pkg::*;
#(
  parameter int unsigned CNT_W  = 12,
  parameter int unsigned TRAN_N = 256,
  parameter logic [SRAM_AW-1:0] RAM1_BASE = 16'h0C00,
  parameter logic [SRAM_AW-1:0] RAM2_BASE = 16'h0D00,
  parameter logic [SRAM_AW-1:0] TRAN_BASE = 16'h0E00,
  parameter logic [PIX_W-1:0]   TRAN_PAT  = 32'h5555_5555
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               pwr_up,
  input  logic               start,
  input  logic [CNT_W-1:0]   count,
  input  logic               pix_valid,
  input  logic [PIX_W-1:0]   pix_data,
  output logic               pix_ready,
  output logic               loading,
  output logic               sram_we,
  output logic [SRAM_AW-1:0] sram_addr,
  output logic [PIX_W-1:0]   sram_wdata
);

  localparam int unsigned TI_W = $clog2(TRAN_N);
  localparam logic [TI_W-1:0] TI_LAST = TI_W'(TRAN_N - 1);

  logic               pix_q, pix_n, tran_q, tran_n;
  logic [TI_W-1:0]    tidx_q, tidx_n;
  logic [SRAM_AW-1:0] ptr_q, ptr_n;
  logic [CNT_W-1:0]   left_q, left_n;
  logic               we_n;
  logic [SRAM_AW-1:0] addr_n;
  logic [PIX_W-1:0]   wdata_n;

  assign pix_ready = pix_q & ~tran_q;
  assign loading   = pix_q;

  always_comb begin
    pix_n   = pix_q;
    tran_n  = tran_q;
    tidx_n  = tidx_q;
    ptr_n   = ptr_q;
    left_n  = left_q;
    we_n    = 1'b0;
    addr_n  = sram_addr;
    wdata_n = sram_wdata;
    if (pwr_up) begin
      tran_n = 1'b1;
      tidx_n = '0;
      pix_n  = 1'b0;
    end else begin
      if (tran_q) begin
        we_n    = 1'b1;
        addr_n  = TRAN_BASE + SRAM_AW'(tidx_q);
        wdata_n = TRAN_PAT;
        tidx_n  = tidx_q + 1'b1;
        if (tidx_q == TI_LAST) tran_n = 1'b0;
      end
      if (start) begin
        pix_n  = 1'b1;
        ptr_n  = RAM1_BASE;
        left_n = count;
      end else if (pix_ready && pix_valid) begin
        we_n    = 1'b1;
        addr_n  = ptr_q;
        wdata_n = argb_swap(pix_data);
        ptr_n   = addr_step(ptr_q, RAM2_BASE);
        left_n  = left_q - 1'b1;
        if (left_q == CNT_W'(1)) pix_n = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pix_q      <= 1'b0;
      tran_q     <= 1'b0;
      tidx_q     <= '0;
      ptr_q      <= RAM1_BASE;
      left_q     <= '0;
      sram_we    <= 1'b0;
      sram_addr  <= '0;
      sram_wdata <= '0;
    end else begin
      pix_q      <= pix_n;
      tran_q     <= tran_n;
      tidx_q     <= tidx_n;
      ptr_q      <= ptr_n;
      left_q     <= left_n;
      sram_we    <= we_n;
      sram_addr  <= addr_n;
      sram_wdata <= wdata_n;
    end
  end

  // R9: every write into the transparency table carries the fill value
  a_r9_tran_fill: assert property (@(posedge clk) disable iff (!rst_n)
    (sram_we && ((sram_addr & ~SRAM_AW'(TRAN_N - 1)) == TRAN_BASE)) |-> sram_wdata == TRAN_PAT);

  // R7: an accepted pixel reaches the port one cycle later, byte-swapped
  a_r7_swizzle: assert property (@(posedge clk) disable iff (!rst_n)
    $past(pix_ready && pix_valid && !pwr_up && !start) |-> (sram_we && sram_wdata == argb_swap($past(pix_data))));

  // R9: no pattern pixel is taken while the fill runs
  a_r9_fill_first: assert property (@(posedge clk) disable iff (!rst_n)
    tran_q |-> !pix_ready);

endmodule

// File: rtl/hwcur_unit.sv
module hwcur_unit
  import hwcur_pkg::*;
#(
  parameter int unsigned POS_W     = 13,
  parameter int unsigned DIM_W     = 12,
  parameter int unsigned SZ_W      = 7,
  parameter int unsigned MAX_SIDE  = 64,
  parameter int unsigned HALF_SIDE = 32,
  localparam int unsigned OFF_W = $clog2(2*MAX_SIDE*MAX_SIDE + MAX_SIDE + 1),
  localparam int unsigned CNT_W = $clog2(MAX_SIDE*HALF_SIDE + 1)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req_valid,
  input  logic                    req_reload,
  input  logic signed [POS_W-1:0] req_x,
  input  logic signed [POS_W-1:0] req_y,
  input  logic [SZ_W-1:0]         req_w,
  input  logic [SZ_W-1:0]         req_h,
  input  logic [DIM_W-1:0]        act_w,
  input  logic [DIM_W-1:0]        act_h,
  input  logic                    interlace,
  input  logic                    frame_done,
  input  logic                    sram_pwr_up,
  input  logic                    pix_valid,
  input  logic [PIX_W-1:0]        pix_data,
  output logic                    pix_ready,
  output logic                    req_reject,
  output logic [31:0]             cur_pos,
  output logic [31:0]             cur_size,
  output logic [OFF_W-1:0]        bmp_off,
  output logic                    cursor_en,
  output logic                    sram_we,
  output logic [SRAM_AW-1:0]      sram_addr,
  output logic [PIX_W-1:0]        sram_wdata
);

  localparam logic [SZ_W-1:0] MAX_L  = SZ_W'(MAX_SIDE);
  localparam logic [SZ_W-1:0] HALF_L = SZ_W'(HALF_SIDE);

  // reset: asynchronous assert, synchronous release
  logic [1:0] rsync;
  logic       rst_i;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync <= 2'b00;
    else        rsync <= {rsync[0], 1'b1};
  end
  assign rst_i = rsync[1];

  // clipping per axis
  logic [DIM_W-1:0] sx, sy, ys;
  logic [SZ_W-1:0]  vw, vh0, vh, ox, oy;
  logic [SZ_W:0]    stride;

  hwcur_axis #(.POS_W(POS_W), .LEN_W(SZ_W), .LIM_W(DIM_W)) i_ax_x (
    .pos(req_x), .len(req_w), .lim(act_w), .scr(sx), .vis(vw), .skip(ox));
  hwcur_axis #(.POS_W(POS_W), .LEN_W(SZ_W), .LIM_W(DIM_W)) i_ax_y (
    .pos(req_y), .len(req_h), .lim(act_h), .scr(sy), .vis(vh0), .skip(oy));

  logic             too_big, accept, visible;
  logic [31:0]      new_pos, new_size;
  logic [OFF_W-1:0] off;
  logic [CNT_W-1:0] pix_cnt;

  always_comb begin
    vh       = interlace ? (vh0 >> 1) : vh0;
    ys       = interlace ? (sy >> 1) : sy;
    stride   = interlace ? {req_w, 1'b0} : {1'b0, req_w};
    too_big  = (req_w > MAX_L) || (req_h > MAX_L) || ((req_w > HALF_L) && (req_h > HALF_L));
    accept   = req_valid && !too_big;
    visible  = (vw != '0) && (vh != '0);
    new_pos  = {16'(ys), 16'(sx)};
    new_size = {16'(vh), 16'(vw)};
    off      = OFF_W'(oy) * OFF_W'(stride) + OFF_W'(ox);
    pix_cnt  = CNT_W'(vw) * CNT_W'(vh);
  end

  // request, load and commit control
  logic [31:0]      pos_q, pos_n, size_q, size_n, ppos_q, ppos_n, psize_q, psize_n, ldsz_q, ldsz_n;
  logic [OFF_W-1:0] off_q, off_n;
  logic             en_q, en_n, pend_q, pend_n, rej_q, rej_n, start, loading;

  always_comb begin
    pos_n   = pos_q;
    size_n  = size_q;
    ppos_n  = ppos_q;
    psize_n = psize_q;
    ldsz_n  = ldsz_q;
    off_n   = off_q;
    en_n    = en_q;
    pend_n  = pend_q;
    rej_n   = req_valid && too_big;
    start   = 1'b0;
    if (sram_pwr_up) begin
      en_n   = 1'b0;
      pend_n = 1'b0;
      ldsz_n = '0;
    end else if (accept) begin
      off_n = off;
      if (!visible) begin
        en_n   = 1'b0;
        pend_n = 1'b0;
      end else begin
        pend_n  = 1'b1;
        ppos_n  = new_pos;
        psize_n = new_size;
        if (new_size != ldsz_q) en_n = 1'b0;
        if ((new_size != ldsz_q) || req_reload) begin
          start  = 1'b1;
          ldsz_n = new_size;
        end
      end
    end else if (frame_done && pend_q && !loading) begin
      pos_n  = ppos_q;
      size_n = psize_q;
      en_n   = 1'b1;
      pend_n = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      pos_q   <= '0;
      size_q  <= '0;
      ppos_q  <= '0;
      psize_q <= '0;
      ldsz_q  <= '0;
      off_q   <= '0;
      en_q    <= 1'b0;
      pend_q  <= 1'b0;
      rej_q   <= 1'b0;
    end else begin
      pos_q   <= pos_n;
      size_q  <= size_n;
      ppos_q  <= ppos_n;
      psize_q <= psize_n;
      ldsz_q  <= ldsz_n;
      off_q   <= off_n;
      en_q    <= en_n;
      pend_q  <= pend_n;
      rej_q   <= rej_n;
    end
  end

  assign cur_pos    = pos_q;
  assign cur_size   = size_q;
  assign bmp_off    = off_q;
  assign cursor_en  = en_q;
  assign req_reject = rej_q;

  hwcur_loader #(.CNT_W(CNT_W)) i_loader (
    .clk(clk), .rst_n(rst_i), .pwr_up(sram_pwr_up), .start(start), .count(pix_cnt),
    .pix_valid(pix_valid), .pix_data(pix_data), .pix_ready(pix_ready), .loading(loading),
    .sram_we(sram_we), .sram_addr(sram_addr), .sram_wdata(sram_wdata));

  // R6: the enable only turns on as a result of a frame-done commit
  a_r6_rise_on_frame: assert property (@(posedge clk) disable iff (!rst_i)
    $rose(cursor_en) |-> $past(frame_done));

  // R5: an enabled cursor never shows a zero visible dimension
  a_r5_nonzero_size: assert property (@(posedge clk) disable iff (!rst_i)
    cursor_en |-> (cur_size[15:0] != 16'd0 && cur_size[31:16] != 16'd0));

  // R1: a rejected request leaves every visible output alone
  a_r1_reject_holds: assert property (@(posedge clk) disable iff (!rst_i)
    req_reject |-> ($stable(cur_pos) && $stable(cursor_en) && $stable(bmp_off) && $stable(cur_size)));

  // R10: the enable is never turned on while pattern pixels are still expected
  a_r10_no_rise_loading: assert property (@(posedge clk) disable iff (!rst_i)
    $rose(cursor_en) |-> !pix_ready);

endmodule

// File: tb/test_hwcur_unit.sv
module test_hwcur_unit;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_reload = 1'b0, interlace = 1'b0;
  logic signed [12:0] req_x = '0, req_y = '0;
  logic [6:0]  req_w = '0, req_h = '0;
  logic [11:0] act_w = 12'd640, act_h = 12'd480;
  logic        frame_done = 1'b0, sram_pwr_up = 1'b0, pix_valid = 1'b0;
  logic [31:0] pix_data = '0;
  logic        pix_ready, req_reject, cursor_en, sram_we;
  logic [31:0] cur_pos, cur_size, sram_wdata;
  logic [13:0] bmp_off;
  logic [15:0] sram_addr;

  int checks = 0;
  int errors = 0;
  logic [47:0] expq[$];
  logic [15:0] exp_ptr;

  always #2 clk = ~clk;

  hwcur_unit i_hwcur_unit (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_reload(req_reload),
    .req_x(req_x), .req_y(req_y), .req_w(req_w), .req_h(req_h), .act_w(act_w), .act_h(act_h),
    .interlace(interlace), .frame_done(frame_done), .sram_pwr_up(sram_pwr_up),
    .pix_valid(pix_valid), .pix_data(pix_data), .pix_ready(pix_ready), .req_reject(req_reject),
    .cur_pos(cur_pos), .cur_size(cur_size), .bmp_off(bmp_off), .cursor_en(cursor_en),
    .sram_we(sram_we), .sram_addr(sram_addr), .sram_wdata(sram_wdata));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] nxt(input logic [15:0] a);
    logic [15:0] n;
    n = a + 16'd1;
    if (n[7:0] == 8'd0) n = n + 16'h0F00;
    if ((n & 16'h30FF) == 16'd0) n = 16'h0D00;
    return n;
  endfunction

  // scoreboard monitor: every write must match the next expected entry
  always @(negedge clk) begin
    if (rst_n && sram_we) begin
      checks++;
      if (expq.size() == 0) begin
        errors++;
        $display("FAIL R8: actual=%0h expected=none (unexpected write)", sram_addr);
      end else begin
        logic [47:0] e;
        e = expq.pop_front();
        if ({sram_addr, sram_wdata} !== e) begin
          errors++;
          $display("FAIL R7/R8/R9: actual=%0h expected=%0h", {sram_addr, sram_wdata}, e);
        end
      end
    end
  end

  task automatic send_req(input int x, input int y, input int w, input int h,
                          input logic il, input logic rl);
    @(negedge clk);
    req_x = 13'(x); req_y = 13'(y); req_w = 7'(w); req_h = 7'(h);
    interlace = il; req_reload = rl; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0; req_reload = 1'b0;
  endtask

  task automatic frame();
    @(negedge clk);
    frame_done = 1'b1;
    @(negedge clk);
    frame_done = 1'b0;
  endtask

  task automatic pwr_up();
    @(negedge clk);
    sram_pwr_up = 1'b1;
    for (int i = 0; i < 256; i++) expq.push_back({16'h0E00 + 16'(i), 32'h5555_5555});
    @(negedge clk);
    sram_pwr_up = 1'b0;
  endtask

  // driver: pushes the expected write, then offers the pixel
  task automatic load(input int n);
    exp_ptr = 16'h0C00;
    for (int i = 0; i < n; i++) begin
      logic [31:0] p;
      while (!pix_ready) @(negedge clk);
      p = 32'h1122_3344 + 32'(i) * 32'h0103_0507;
      expq.push_back({exp_ptr, p[31:24], p[7:0], p[15:8], p[23:16]});
      exp_ptr = nxt(exp_ptr);
      pix_data = p; pix_valid = 1'b1;
      @(negedge clk);
    end
    pix_valid = 1'b0;
    chk("R10 pix_ready low after count", 32'(pix_ready), 32'd0);
    @(negedge clk);
    chk("R8 scoreboard drained", 32'(expq.size()), 32'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("reset cursor_en", 32'(cursor_en), 32'd0);
    chk("reset cur_pos", cur_pos, 32'd0);
    chk("reset cur_size", cur_size, 32'd0);
    chk("reset pix_ready", 32'(pix_ready), 32'd0);

    // R9 fill after power-up
    pwr_up();
    chk("R9 no pixel during fill", 32'(pix_ready), 32'd0);
    repeat (262) @(negedge clk);
    chk("R9 fill drained", 32'(expq.size()), 32'd0);

    // R10 / R6 basic placement
    send_req(10, 20, 16, 8, 1'b0, 1'b0);
    chk("R10 load armed", 32'(pix_ready), 32'd1);
    chk("R10 cursor off", 32'(cursor_en), 32'd0);
    chk("R12 off zero", 32'(bmp_off), 32'd0);
    frame();
    chk("R6 no commit while loading", 32'(cursor_en), 32'd0);
    load(128);
    frame();
    chk("R6 pos", cur_pos, {16'd20, 16'd10});
    chk("R6 size", cur_size, {16'd8, 16'd16});
    chk("R6 enable", 32'(cursor_en), 32'd1);

    // R11 move with same size
    send_req(100, 50, 16, 8, 1'b0, 1'b0);
    chk("R11 no load", 32'(pix_ready), 32'd0);
    chk("R11 stays on", 32'(cursor_en), 32'd1);
    chk("R11 pos held until frame", cur_pos, {16'd20, 16'd10});
    frame();
    chk("R11 pos after frame", cur_pos, {16'd50, 16'd100});

    // R1 rejection
    send_req(0, 0, 65, 4, 1'b0, 1'b0);
    chk("R1 reject wide", 32'(req_reject), 32'd1);
    chk("R1 pos kept", cur_pos, {16'd50, 16'd100});
    send_req(0, 0, 33, 33, 1'b0, 1'b0);
    chk("R1 reject both", 32'(req_reject), 32'd1);
    chk("R1 enable kept", 32'(cursor_en), 32'd1);

    // R2 left/top clip
    send_req(-5, -3, 16, 8, 1'b0, 1'b0);
    chk("R1 accepted", 32'(req_reject), 32'd0);
    chk("R12 offset 3*16+5", 32'(bmp_off), 32'd53);
    load(55);
    frame();
    chk("R2 pos", cur_pos, 32'd0);
    chk("R2 size", cur_size, {16'd5, 16'd11});

    // R3 right/bottom clip
    send_req(630, 476, 16, 8, 1'b0, 1'b0);
    load(40);
    frame();
    chk("R3 pos", cur_pos, {16'd476, 16'd630});
    chk("R3 size", cur_size, {16'd4, 16'd10});

    // R4 interlace
    send_req(-1, -2, 16, 8, 1'b1, 1'b0);
    chk("R4 R12 offset 2*32+1", 32'(bmp_off), 32'd65);
    load(45);
    frame();
    chk("R4 size halved", cur_size, {16'd3, 16'd15});
    send_req(0, 21, 16, 8, 1'b1, 1'b0);
    load(64);
    frame();
    chk("R4 y halved", cur_pos, {16'd10, 16'd0});
    chk("R4 size", cur_size, {16'd4, 16'd16});

    // R5 nothing visible
    send_req(700, 10, 16, 8, 1'b0, 1'b0);
    chk("R5 off screen disables", 32'(cursor_en), 32'd0);
    send_req(0, 0, 16, 1, 1'b1, 1'b0);
    chk("R5 halved height zero", 32'(cursor_en), 32'd0);

    // R8 full 64x32 load crosses every bank step
    send_req(0, 0, 64, 32, 1'b0, 1'b0);
    chk("R1 64x32 accepted", 32'(req_reject), 32'd0);
    load(2048);
    frame();
    chk("R8 size", cur_size, {16'd32, 16'd64});
    chk("R8 enable", 32'(cursor_en), 32'd1);

    // R9 power-up while on, request during fill
    pwr_up();
    chk("R9 disable", 32'(cursor_en), 32'd0);
    send_req(2, 3, 4, 4, 1'b0, 1'b0);
    chk("R9 held during fill", 32'(pix_ready), 32'd0);
    load(16);
    frame();
    chk("R9 reload committed", cur_size, {16'd4, 16'd4});
    chk("R9 enable", 32'(cursor_en), 32'd1);

    // R10 forced reload keeps enable
    send_req(2, 3, 4, 4, 1'b0, 1'b1);
    chk("R10 reload same size stays on", 32'(cursor_en), 32'd1);
    load(16);

    repeat (4) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule